// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block models a small non-volatile memory reached over a three-wire serial link: a select line, a serial clock and a data input, plus one data output. The memory holds 128 words of 16 bits. A host frames each instruction with the select line. It sends a start bit and a two-bit operation code, then an eight-bit address field. A data word follows when the instruction needs one. All serial lines are sampled by a free-running system clock, so the serial clock is treated as an ordinary input whose rising edges are detected in logic.

Seven operations are decoded: read a word, write a word, erase a word to all ones, erase the whole array, write one value to the whole array, and turn the programming permission on or off. Programming is locked after reset until the unlock operation has run. Each accepted programming operation starts a self-timed busy period of a fixed number of system clocks. During that period the host can poll the output for a busy or ready indication by dropping and raising the select line.

Top module: `wire3_eeprom`

## Requirements
- R1: With select high, the data input is sampled on each rising serial clock. Zeros before the first 1 are skipped. That 1 is the start bit, and it is followed by a 2-bit operation code and an 8-bit address, both sent MSB first.
- R2: Operation code 10 reads. Once the last address bit is taken, the output shows a 0 dummy bit. Each later rising serial clock then presents the next of the 16 data bits, MSB first, and after the last bit the output stays 0. While select is low, and when no read or status display is active, the output is 0.
- R3: After reset, programming is locked, and erase, write, erase-all and write-all change no word and start no busy period. Operation code 00 with address bits [7:6]=11 unlocks. Operation code 00 with bits [7:6]=00 locks again.
- R4: A read returns stored data whether programming is locked or unlocked.
- R5: Operation code 01 writes: the 16 bits after the address are stored MSB first at the word given by address bits [6:0]. Address bit 7 plays no part in selecting a word, for reads or for writes.
- R6: Operation code 11 sets every bit of the addressed word to 1.
- R7: Operation code 00 with bits [7:6]=10 sets every word to all ones. With bits [7:6]=01, the following 16-bit word is stored in every location.
- R8: An accepted erase or erase-all starts a busy period when its last address bit arrives. An accepted write or write-all starts one when its last data bit arrives. The busy period lasts exactly TWP_CYCLES system clocks, and start bits sent during it are ignored.
- R9: If select rises while the busy period runs, the output shows 0 until the period ends and 1 afterwards, until select falls. If select rises after the period has ended, the output stays 0.
- R10: If select falls before an instruction is complete, the instruction is dropped and no word is changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the serial lines and times the busy period |
| rstN | input | 1 | Asynchronous active-low reset |
| csIn | input | 1 | Chip select, active high; frames each instruction |
| skIn | input | 1 | Serial clock from the host |
| diIn | input | 1 | Serial data from the host |
| doOut | output | 1 | Serial data to the host: read bits or busy/ready status |

## Verification
A wrong bit counter or a wrong decoder state shows up at the output within one serial bit. The dummy bit or the first data bit of the next read would land in the wrong place, or a status indication would appear where the output should be 0. A wrong permission latch or a wrong array write stays hidden until the affected word is read back, so every programming step is followed by reads of the word it targeted and of a word it must not touch. A busy counter that is off by even one clock shows in the status polling: the reference model follows the ready edge cycle by cycle and compares the output on every clock.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_DATA,
    S_READ,
    S_HOLD
  } ctrlState_t;

  localparam logic [1:0] OP_MISC  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_WIPE   = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;

  typedef struct packed {
    logic shiftIn;    // take diIn into the input shifter
    logic latchAddr;  // last address bit: capture word index
    logic loadRead;   // load output shifter from array
    logic shiftOut;   // present next read bit
    logic progWord;   // program one word, start timer
    logic progAll;    // program every word, start timer
    logic fillOnes;   // program value is all ones
  } strobe_t;

endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int CMD_BITS  = 10,
  parameter int WORD_BITS = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csIn,
  input  logic    skIn,
  input  logic    diIn,
  input  logic    busy,
  input  logic [1:0] opField,
  input  logic [1:0] subField,
  output strobe_t strb,
  output logic    enLatch,
  output logic    reading,
  output logic    statusOn
);

  localparam int MAX_BITS = (CMD_BITS > WORD_BITS) ? CMD_BITS : WORD_BITS;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_BITS - 1);

  ctrlState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic skPrev;
  logic csPrev;
  logic fillAll;

  logic skRise;
  logic csRise;
  logic startOk;
  logic lastCmd;
  logic lastData;

  assign skRise   = skIn & ~skPrev;
  assign csRise   = csIn & ~csPrev;
  assign startOk  = csIn && skRise && (state == S_IDLE) && diIn && !busy;
  assign lastCmd  = csIn && skRise && (state == S_CMD)  && (bitCnt == CMD_LAST);
  assign lastData = csIn && skRise && (state == S_DATA) && (bitCnt == WORD_LAST);

  always_comb begin
    strb = '0;
    if (csIn && skRise) begin
      strb.shiftIn  = (state == S_CMD) || (state == S_DATA);
      strb.shiftOut = (state == S_READ);
    end
    if (lastCmd) begin
      strb.latchAddr = 1'b1;
      unique case (opField)
        OP_READ:  strb.loadRead = 1'b1;
        OP_ERASE: begin
          strb.progWord = enLatch;
          strb.fillOnes = 1'b1;
        end
        OP_MISC: begin
          if (subField == SUB_WIPE) begin
            strb.progAll  = enLatch;
            strb.fillOnes = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (lastData && enLatch) begin
      strb.progAll  = fillAll;
      strb.progWord = ~fillAll;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skPrev <= 1'b0;
      csPrev <= 1'b0;
    end else begin
      skPrev <= skIn;
      csPrev <= csIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      fillAll  <= 1'b0;
      enLatch  <= 1'b0;
      reading  <= 1'b0;
      statusOn <= 1'b0;
    end else if (!csIn) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      reading  <= 1'b0;
      statusOn <= 1'b0;
    end else begin
      if (csRise && busy) begin
        statusOn <= 1'b1;
      end else if (startOk) begin
        statusOn <= 1'b0;
      end
      if (startOk) begin
        state  <= S_CMD;
        bitCnt <= '0;
      end else if (skRise) begin
        unique case (state)
          S_CMD: begin
            if (lastCmd) begin
              bitCnt <= '0;
              state  <= S_HOLD;
              unique case (opField)
                OP_READ: begin
                  state   <= S_READ;
                  reading <= 1'b1;
                end
                OP_WRITE: begin
                  state   <= S_DATA;
                  fillAll <= 1'b0;
                end
                OP_MISC: begin
                  if (subField == SUB_UNLOCK) enLatch <= 1'b1;
                  if (subField == SUB_LOCK)   enLatch <= 1'b0;
                  if (subField == SUB_FILL) begin
                    state   <= S_DATA;
                    fillAll <= 1'b1;
                  end
                end
                default: ;
              endcase
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          S_DATA: begin
            if (lastData) begin
              state <= S_HOLD;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/eeprom_dpath.sv
module eeprom_dpath
  import eeprom_pkg::*;
#(
  parameter int ADDR_BITS  = 8,
  parameter int WORD_BITS  = 16,
  parameter int TWP_CYCLES = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    diIn,
  input  strobe_t strb,
  input  logic    reading,
  input  logic    statusOn,
  output logic [1:0] opField,
  output logic [1:0] subField,
  output logic    busy,
  output logic    doOut
);

  localparam int CMD_BITS   = ADDR_BITS + 2;
  localparam int SHIFT_BITS = (CMD_BITS > WORD_BITS) ? CMD_BITS : WORD_BITS;
  localparam int IDX_BITS   = ADDR_BITS - 1;
  localparam int DEPTH      = 1 << IDX_BITS;
  localparam int TMR_W      = $clog2(TWP_CYCLES + 1);

  logic [SHIFT_BITS-2:0] shiftReg;
  logic [SHIFT_BITS-1:0] newBits;
  logic [IDX_BITS-1:0]   addrReg;
  logic [IDX_BITS-1:0]   progAddr;
  logic [WORD_BITS-1:0]  progData;
  logic [WORD_BITS-1:0]  mem [DEPTH];
  logic [WORD_BITS-1:0]  outReg;
  logic                  outBit;
  logic [TMR_W-1:0]      tmr;

  assign newBits  = {shiftReg, diIn};
  assign opField  = newBits[CMD_BITS-1 -: 2];
  assign subField = newBits[CMD_BITS-3 -: 2];
  assign progAddr = strb.latchAddr ? newBits[IDX_BITS-1:0] : addrReg;
  assign progData = strb.fillOnes ? '1 : newBits[WORD_BITS-1:0];
  assign busy     = (tmr != '0);
  assign doOut    = statusOn ? ~busy : (reading & outBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      addrReg  <= '0;
    end else begin
      if (strb.shiftIn)   shiftReg <= newBits[SHIFT_BITS-2:0];
      if (strb.latchAddr) addrReg  <= newBits[IDX_BITS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.progAll) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= progData;
    end else if (strb.progWord) begin
      mem[progAddr] <= progData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      outBit <= 1'b0;
    end else if (strb.loadRead) begin
      outReg <= mem[progAddr];
      outBit <= 1'b0;
    end else if (strb.shiftOut) begin
      outBit <= outReg[WORD_BITS-1];
      outReg <= {outReg[WORD_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (strb.progWord || strb.progAll) begin
      tmr <= TMR_W'(TWP_CYCLES);
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end

endmodule

// File: rtl/wire3_eeprom.sv
module wire3_eeprom
  import eeprom_pkg::*;
#(
  parameter int ADDR_BITS  = 8,
  parameter int WORD_BITS  = 16,
  parameter int TWP_CYCLES = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut
);

  localparam int CMD_BITS = ADDR_BITS + 2;

  strobe_t    strb;
  logic       enLatch;
  logic       reading;
  logic       statusOn;
  logic       busy;
  logic       progAny;
  logic [1:0] opField;
  logic [1:0] subField;

  assign progAny = strb.progWord | strb.progAll;

  eeprom_ctrl #(
    .CMD_BITS (CMD_BITS),
    .WORD_BITS(WORD_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csIn    (csIn),
    .skIn    (skIn),
    .diIn    (diIn),
    .busy    (busy),
    .opField (opField),
    .subField(subField),
    .strb    (strb),
    .enLatch (enLatch),
    .reading (reading),
    .statusOn(statusOn)
  );

  eeprom_dpath #(
    .ADDR_BITS (ADDR_BITS),
    .WORD_BITS (WORD_BITS),
    .TWP_CYCLES(TWP_CYCLES)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .diIn    (diIn),
    .strb    (strb),
    .reading (reading),
    .statusOn(statusOn),
    .opField (opField),
    .subField(subField),
    .busy    (busy),
    .doOut   (doOut)
  );

endmodule

// File: rtl/eeprom_checker.sv
module eeprom_checker #(
  parameter int TWP_CYCLES = 64
) (
  input logic clk,
  input logic rstN,
  input logic csIn,
  input logic doOut,
  input logic wrEn,
  input logic prog,
  input logic busy
);

  int runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else runLen <= 0;
  end

  AST_PROG_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rstN)
    prog |-> wrEn); // R3

  AST_PROG_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    prog |=> busy); // R8

  AST_NO_PROG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !prog); // R8

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == TWP_CYCLES)); // R8

  AST_DO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !csIn |=> !doOut); // R9

endmodule

bind wire3_eeprom eeprom_checker #(.TWP_CYCLES(TWP_CYCLES)) chk (
  .clk  (clk),
  .rstN (rstN),
  .csIn (csIn),
  .doOut(doOut),
  .wrEn (enLatch),
  .prog (progAny),
  .busy (busy)
);

// File: tb/tb_wire3_eeprom.sv
module tb_wire3_eeprom;

  localparam int CLK_PERIOD = 10;
  localparam int TWP = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIn = 1'b0;
  logic skIn = 1'b0;
  logic diIn = 1'b0;
  logic doOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wire3_eeprom #(.ADDR_BITS(8), .WORD_BITS(16), .TWP_CYCLES(TWP)) dut (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn), .doOut(doOut)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] mm [128];
  bit   mq[$];
  int   mState, mN, mAcc, mTimer, mAddr;
  bit   mEn, mAll, mStatus, mReading, mOutBit, mSkPrev, mCsPrev;
  bit   expDo;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mN = 0; mAcc = 0; mTimer = 0; mAddr = 0;
      mEn = 0; mAll = 0; mStatus = 0; mReading = 0; mOutBit = 0;
      mSkPrev = 0; mCsPrev = 0; mq.delete();
    end else begin
      bit oldBusy, rise, csRise, startT;
      int op, a, sub, idx;
      oldBusy = (mTimer > 0);
      rise = skIn && !mSkPrev;
      csRise = csIn && !mCsPrev;
      startT = 0;
      if (!csIn) begin
        mState = 0; mReading = 0; mStatus = 0;
      end else begin
        if (csRise && oldBusy) mStatus = 1;
        if (rise) begin
          case (mState)
            0: if (diIn && !oldBusy) begin
                 mState = 1; mN = 0; mAcc = 0; mStatus = 0;
               end
            1: begin
                 mAcc = mAcc * 2 + int'(diIn);
                 mN++;
                 if (mN == 10) begin
                   op = (mAcc >> 8) & 3; a = mAcc & 255; sub = a >> 6; idx = a & 127;
                   mState = 4;
                   if (op == 2) begin
                     mReading = 1; mOutBit = 0; mq.delete();
                     for (int i = 15; i >= 0; i--) mq.push_back(mm[idx][i]);
                     mState = 3;
                   end else if (op == 1) begin
                     mAll = 0; mAddr = idx; mState = 2; mN = 0; mAcc = 0;
                   end else if (op == 3) begin
                     if (mEn) begin mm[idx] = 16'hFFFF; startT = 1; end
                   end else begin
                     if (sub == 3) mEn = 1;
                     else if (sub == 0) mEn = 0;
                     else if (sub == 2) begin
                       if (mEn) begin
                         for (int i = 0; i < 128; i++) mm[i] = 16'hFFFF;
                         startT = 1;
                       end
                     end else begin
                       mAll = 1; mState = 2; mN = 0; mAcc = 0;
                     end
                   end
                 end
               end
            2: begin
                 mAcc = mAcc * 2 + int'(diIn);
                 mN++;
                 if (mN == 16) begin
                   if (mEn) begin
                     if (mAll) for (int i = 0; i < 128; i++) mm[i] = mAcc[15:0];
                     else mm[mAddr] = mAcc[15:0];
                     startT = 1;
                   end
                   mState = 4;
                 end
               end
            3: mOutBit = (mq.size() > 0) ? mq.pop_front() : 1'b0;
            default: ;
          endcase
        end
      end
      if (startT) mTimer = TWP;
      else if (mTimer > 0) mTimer--;
      mSkPrev = skIn;
      mCsPrev = csIn;
      expDo = mStatus ? (mTimer == 0) : (mReading && mOutBit);
    end
  end

  // Every-clock comparison of the serial output (R2, R9)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (doOut !== expDo) begin
        failures++;
        $display("FAIL R2/R9 stream t=%0t act=%b exp=%b", $time, doOut, expDo);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(logic b);
    @(negedge clk); diIn = b; skIn = 1'b1;
    @(negedge clk);
    @(negedge clk); skIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendCmd(logic [1:0] op, logic [7:0] a, int zeros);
    for (int i = 0; i < zeros; i++) sendBit(1'b0);
    sendBit(1'b1);
    for (int i = 1; i >= 0; i--) sendBit(op[i]);
    for (int i = 7; i >= 0; i--) sendBit(a[i]);
  endtask

  task automatic runInstr(logic [1:0] op, logic [7:0] a, bit withData, logic [15:0] d);
    @(negedge clk); csIn = 1'b1;
    tick(1);
    sendCmd(op, a, 0);
    if (withData) for (int i = 15; i >= 0; i--) sendBit(d[i]);
    @(negedge clk); csIn = 1'b0;
    tick(2);
  endtask

  task automatic readWord(logic [7:0] a, int zeros, output logic [15:0] w);
    @(negedge clk); csIn = 1'b1;
    tick(1);
    sendCmd(2'b10, a, zeros);
    check("R2 dummy bit", {15'd0, doOut}, 16'd0);
    for (int i = 15; i >= 0; i--) begin
      sendBit(1'b0);
      w[i] = doOut;
    end
    sendBit(1'b0);
    check("R2 output after last bit", {15'd0, doOut}, 16'd0);
    @(negedge clk); csIn = 1'b0;
    tick(2);
  endtask

  logic [15:0] rd;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    check("R2 reset output low", {15'd0, doOut}, 16'd0);

    // unlock, wipe all, read back
    runInstr(2'b00, 8'hC0, 0, 16'h0);          // R3 unlock
    runInstr(2'b00, 8'h80, 0, 16'h0);          // R7 erase all
    tick(TWP + 10);
    readWord(8'd5, 0, rd);   check("R7 erase-all word 5", rd, 16'hFFFF);
    readWord(8'd127, 0, rd); check("R7 erase-all word 127", rd, 16'hFFFF);

    // lock, attempt write
    runInstr(2'b00, 8'h00, 0, 16'h0);          // R3 lock
    runInstr(2'b01, 8'd5, 1, 16'h1234);
    @(negedge clk); csIn = 1'b1; tick(2);
    check("R3 no busy when locked", {15'd0, doOut}, 16'd0);
    csIn = 1'b0; tick(2);
    readWord(8'd5, 0, rd); check("R3 locked write ignored", rd, 16'hFFFF);

    // unlocked write with status polling
    runInstr(2'b00, 8'hFF, 0, 16'h0);          // R3 unlock, low bits don't care
    runInstr(2'b01, 8'd5, 1, 16'hA5C3);
    @(negedge clk); csIn = 1'b1; tick(2);
    check("R9 busy shows 0", {15'd0, doOut}, 16'd0);
    tick(TWP);
    check("R9 ready shows 1", {15'd0, doOut}, 16'd1);
    csIn = 1'b0; tick(2);
    readWord(8'd5, 0, rd);    check("R5 write word 5", rd, 16'hA5C3);
    readWord(8'h85, 0, rd);   check("R5 address bit 7 ignored", rd, 16'hA5C3);
    readWord(8'd5, 3, rd);    check("R1 leading zeros skipped", rd, 16'hA5C3);

    // instruction during busy is ignored
    runInstr(2'b01, 8'd9, 1, 16'h1111);
    runInstr(2'b01, 8'd10, 1, 16'h2222);
    tick(TWP + 10);
    readWord(8'd10, 0, rd); check("R8 write during busy ignored", rd, 16'hFFFF);
    readWord(8'd9, 0, rd);  check("R5 write word 9", rd, 16'h1111);

    // status after cycle end shows nothing
    runInstr(2'b01, 8'd11, 1, 16'h0F0F);
    tick(TWP + 10);
    @(negedge clk); csIn = 1'b1; tick(3);
    check("R9 no status after end", {15'd0, doOut}, 16'd0);
    csIn = 1'b0; tick(2);

    // erase one word
    runInstr(2'b11, 8'd9, 0, 16'h0);
    tick(TWP + 10);
    readWord(8'd9, 0, rd);  check("R6 erase word 9", rd, 16'hFFFF);
    readWord(8'd11, 0, rd); check("R6 neighbour kept", rd, 16'h0F0F);

    // abort mid data
    @(negedge clk); csIn = 1'b1; tick(1);
    sendCmd(2'b01, 8'd20, 0);
    for (int i = 0; i < 7; i++) sendBit(1'b0);
    @(negedge clk); csIn = 1'b0; tick(TWP + 5);
    readWord(8'd20, 0, rd); check("R10 aborted write", rd, 16'hFFFF);

    // write all, then read while locked
    runInstr(2'b00, 8'h40, 1, 16'h3C3C);
    tick(TWP + 10);
    runInstr(2'b00, 8'h00, 0, 16'h0);          // lock
    readWord(8'd0, 0, rd);   check("R7 write-all word 0", rd, 16'h3C3C);
    readWord(8'd127, 0, rd); check("R4 read while locked", rd, 16'h3C3C);
    runInstr(2'b00, 8'h80, 0, 16'h0);          // erase all while locked
    tick(TWP + 10);
    readWord(8'd64, 0, rd);  check("R3 locked erase-all ignored", rd, 16'h3C3C);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule